// File: doc/BRIEF.md
# Protection-Key Access Permission Checker

This block decides, for each data access, whether the page's protection key lets it through under the current thread's key rights. It keeps a rights register that holds a two-bit field for each key. A four-bit key is taken from a fixed field of the 64-bit page translation entry, and the matching field is looked up combinationally. The result then depends on the access type, the privilege mode and two control enables. The block returns allow or deny. On a deny it raises a key-fault flag, separate from every other fault type, and reports the offending key.

Software reads and writes the rights register through dedicated read and write strobes. Each strobe is qualified by a selector that must be zero. A write changes the decision for accesses checked from the next cycle on. Page walking, translation caching, instruction-fetch rules and the ordinary page permission bits belong to other stages.

Top module: `pkey_access_check`

## Requirements
- R1: The protection key is bits 62 down to 59 of `pageEntry`. No other entry bit affects the decision.
- R2: In the rights register, bit 2k is the access-disable flag of key k and bit 2k+1 is its write-disable flag. When both flags of the selected key are 0, every access is allowed.
- R3: When `keysOn`=1 and `userPage`=1 and the key's access-disable bit is 1, both reads and writes are denied, in either privilege mode.
- R4: When `keysOn`=1, `userPage`=1, `accSuper`=0 and `accWrite`=1, an access to a key whose write-disable bit is 1 is denied. A read (`accWrite`=0) is not denied by the write-disable bit.
- R5: A supervisor-mode write (`accSuper`=1, `accWrite`=1) to a key whose write-disable bit is 1 is denied when `supWpOn`=1 and allowed when `supWpOn`=0, provided its access-disable bit is 0.
- R6: When `userPage`=0 (a supervisor-mode address), the access is always allowed, whatever the key and its rights.
- R7: When `keysOn`=0, every access is allowed.
- R8: After reset the rights register holds 0x55555554. Only key 0 allows full access, and keys 1 to 15 are access-disabled.
- R9: A write with `regWrEn`=1 and `regSel`=0 loads `regWrData` at the clock edge. The new rights govern accesses from the next cycle on. A write with a nonzero `regSel` leaves the register unchanged.
- R10: With `regRdEn`=1 and `regSel`=0, `regRdData` shows the rights register. In every other case `regRdData` is 0.
- R11: `keyFault` is the inverse of `allow`. `faultKey` shows the key while `keyFault` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Rights register write strobe |
| regRdEn | input | 1 | Rights register read strobe |
| regSel | input | 32 | Selector; the operation takes effect only when zero |
| regWrData | input | 32 | Rights value to write |
| regRdData | output | 32 | Rights value read back, or 0 |
| pageEntry | input | 64 | Translation entry of the page being accessed |
| userPage | input | 1 | 1 = user-mode address, 0 = supervisor-mode address |
| accSuper | input | 1 | 1 = access made in supervisor mode |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| keysOn | input | 1 | Global key-checking enable |
| supWpOn | input | 1 | Supervisor write-protect enable |
| allow | output | 1 | Access passes the key check |
| keyFault | output | 1 | Access denied by the key check |
| faultKey | output | 4 | Offending key while keyFault is 1, else 0 |

## Verification
The assertions assume the access inputs and the entry are steady while the decision is sampled. They also assume every register operation is a single-cycle strobe with a defined selector. The stimulus changes inputs only on the falling edge and keeps each write strobe high for exactly one cycle. The sweep covers all sixteen keys with every combination of the five access controls, under several rights patterns that mix the two flags per key. Writes and reads with a nonzero selector are mixed in to show that those operations have no effect.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  localparam int PK_KEY_W   = 4;
  localparam int PK_KEY_LSB = 59;
  localparam int PK_ENTRY_W = 64;
  localparam int PK_SEL_W   = 32;
  localparam int PK_NUM_KEYS = 1 << PK_KEY_W;
  localparam int PK_RIGHTS_W = 2 * PK_NUM_KEYS;

  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } rightsCtl_t;
endpackage

// File: rtl/pkey_ctl.sv
module pkey_ctl
  import pkey_pkg::*;
#(
  parameter int SEL_W = PK_SEL_W
) (
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [SEL_W-1:0] regSel,
  output rightsCtl_t       ctl
);
  logic selOk;

  always_comb begin
    selOk        = (regSel == '0);
    ctl.wrStrobe = regWrEn && selOk;
    ctl.rdStrobe = regRdEn && selOk;
  end
endmodule

// File: rtl/pkey_dp.sv
module pkey_dp
  import pkey_pkg::*;
#(
  parameter int KEY_W   = PK_KEY_W,
  parameter int KEY_LSB = PK_KEY_LSB,
  parameter int ENTRY_W = PK_ENTRY_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rightsCtl_t             ctl,
  input  logic [2*(1<<KEY_W)-1:0] regWrData,
  output logic [2*(1<<KEY_W)-1:0] regRdData,
  output logic [2*(1<<KEY_W)-1:0] rightsQ,
  input  logic [ENTRY_W-1:0]     pageEntry,
  input  logic                   userPage,
  input  logic                   accSuper,
  input  logic                   accWrite,
  input  logic                   keysOn,
  input  logic                   supWpOn,
  output logic                   allow,
  output logic                   keyFault,
  output logic [KEY_W-1:0]       faultKey
);
  localparam int NUM_KEYS = 1 << KEY_W;
  localparam int RIGHTS_W = 2 * NUM_KEYS;

  function automatic logic [RIGHTS_W-1:0] initRights();
    logic [RIGHTS_W-1:0] v;
    v = '0;
    for (int i = 1; i < NUM_KEYS; i++) v[2*i] = 1'b1;
    return v;
  endfunction

  localparam logic [RIGHTS_W-1:0] RESET_RIGHTS = initRights();

  logic [NUM_KEYS-1:0] adVec;
  logic [NUM_KEYS-1:0] wdVec;
  logic [KEY_W-1:0]    key;
  logic                adBit;
  logic                wdBit;
  logic                wrBlocked;
  logic                deny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rightsQ <= RESET_RIGHTS;
    else if (ctl.wrStrobe) rightsQ <= regWrData;
  end

  assign regRdData = ctl.rdStrobe ? rightsQ : '0;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_keyField
    assign adVec[k] = rightsQ[2*k];
    assign wdVec[k] = rightsQ[2*k+1];
  end

  always_comb begin
    key       = pageEntry[KEY_LSB +: KEY_W];
    adBit     = adVec[key];
    wdBit     = wdVec[key];
    wrBlocked = accWrite && wdBit && (!accSuper || supWpOn);
    deny      = keysOn && userPage && (adBit || wrBlocked);
    allow     = !deny;
    keyFault  = deny;
    faultKey  = deny ? key : '0;
  end
endmodule

// File: rtl/pkey_access_check.sv
module pkey_access_check
  import pkey_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [PK_SEL_W-1:0]    regSel,
  input  logic [PK_RIGHTS_W-1:0] regWrData,
  output logic [PK_RIGHTS_W-1:0] regRdData,
  input  logic [PK_ENTRY_W-1:0]  pageEntry,
  input  logic                   userPage,
  input  logic                   accSuper,
  input  logic                   accWrite,
  input  logic                   keysOn,
  input  logic                   supWpOn,
  output logic                   allow,
  output logic                   keyFault,
  output logic [PK_KEY_W-1:0]    faultKey
);
  rightsCtl_t             ctl;
  logic [PK_RIGHTS_W-1:0] rightsQ;

  pkey_ctl #(.SEL_W(PK_SEL_W)) u_ctl (
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regSel (regSel),
    .ctl    (ctl)
  );

  pkey_dp #(.KEY_W(PK_KEY_W), .KEY_LSB(PK_KEY_LSB), .ENTRY_W(PK_ENTRY_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .rightsQ  (rightsQ),
    .pageEntry(pageEntry),
    .userPage (userPage),
    .accSuper (accSuper),
    .accWrite (accWrite),
    .keysOn   (keysOn),
    .supWpOn  (supWpOn),
    .allow    (allow),
    .keyFault (keyFault),
    .faultKey (faultKey)
  );
endmodule

// File: rtl/pkey_access_check_chk.sv
module pkey_access_check_chk
  import pkey_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWrEn,
  input logic                   regRdEn,
  input logic [PK_SEL_W-1:0]    regSel,
  input logic [PK_RIGHTS_W-1:0] regWrData,
  input logic [PK_RIGHTS_W-1:0] regRdData,
  input logic [PK_RIGHTS_W-1:0] rightsQ,
  input logic [PK_ENTRY_W-1:0]  pageEntry,
  input logic                   userPage,
  input logic                   keysOn,
  input logic                   allow,
  input logic                   keyFault,
  input logic [PK_KEY_W-1:0]    faultKey
);
  // R7
  keys_off_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !keysOn |-> allow);

  // R6
  sup_addr_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !userPage |-> allow);

  // R11
  fault_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyFault |-> (faultKey == pageEntry[PK_KEY_LSB +: PK_KEY_W]) && !allow);

  // R11
  no_fault_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    allow |-> (faultKey == '0) && !keyFault);

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == '0) |=> (!regRdEn || regSel != '0 || regRdData == $past(regWrData)));

  // R9
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regSel == '0) |=> $stable(rightsQ));

  // R10
  read_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regSel == '0) |-> regRdData == '0);
endmodule

bind pkey_access_check pkey_access_check_chk u_chk (.*);

// File: tb/tb_pkey_access_check.sv
`timescale 1ns/1ps
module tb_pkey_access_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] pageEntry = '0;
  logic        userPage = 1'b0;
  logic        accSuper = 1'b0;
  logic        accWrite = 1'b0;
  logic        keysOn = 1'b0;
  logic        supWpOn = 1'b0;
  logic        allow;
  logic        keyFault;
  logic [3:0]  faultKey;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkey_access_check dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] v, input logic [31:0] s);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0; regSel = '0;
  endtask

  task automatic regRead(input logic [31:0] s, output logic [31:0] v);
    regRdEn = 1'b1; regSel = s;
    #1 v = regRdData;
    regRdEn = 1'b0; regSel = '0;
    #0.1;
  endtask

  // Expected decision from the stated rules
  task automatic sweep(input logic [31:0] rights);
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < 32; c++) begin
        logic ad, wd, dn;
        string tag;
        ad = rights[2*k];
        wd = rights[2*k+1];
        keysOn   = c[0];
        userPage = c[1];
        accSuper = c[2];
        accWrite = c[3];
        supWpOn  = c[4];
        // R1: fill every non-key bit with a pattern that must not matter
        pageEntry = {~k[0], k[3:0], 59'h5A5_A5A5_A5A5_A5A5} ^ {1'b0, 4'h0, {59{c[0]}}};
        dn = keysOn && userPage && (ad || (accWrite && wd && (!accSuper || supWpOn)));
        if (!keysOn) tag = "R7";
        else if (!userPage) tag = "R6";
        else if (ad) tag = "R3";
        else if (accWrite && wd && !accSuper) tag = "R4";
        else if (accWrite && wd) tag = "R5";
        else tag = "R2/R1";
        #1;
        chk(tag, allow, !dn);
        chk("R11", {keyFault, faultKey}, {dn, dn ? k[3:0] : 4'h0});
        @(negedge clk);
      end
    end
  endtask

  initial begin
    logic [31:0] rd;
    #1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset value and its effect
    regRead(32'h0, rd);
    chk("R8", rd, 32'h5555_5554);
    sweep(32'h5555_5554);

    // R10: nonzero selector reads zero
    regRead(32'h1, rd);
    chk("R10", rd, 32'h0);

    // R9: write with nonzero selector ignored
    regWrite(32'h0000_0000, 32'h0000_0100);
    regRead(32'h0, rd);
    chk("R9", rd, 32'h5555_5554);

    // R9: write lands, takes effect on the very next cycle
    regWrite(32'hFFFF_FFF3, 32'h0);
    keysOn = 1'b1; userPage = 1'b1; accSuper = 1'b0; accWrite = 1'b1; supWpOn = 1'b0;
    pageEntry = 64'h0800_0000_0000_0000; // key 1
    #1 chk("R9", allow, 1'b1);
    pageEntry = 64'h0;                   // key 0
    #0.1 chk("R9", allow, 1'b0);
    regRead(32'h0, rd);
    chk("R10", rd, 32'hFFFF_FFF3);
    @(negedge clk);

    sweep(32'hFFFF_FFF3);
    regWrite(32'h0, 32'h0);
    sweep(32'h0);
    regWrite(32'hAAAA_AAAA, 32'h0);
    sweep(32'hAAAA_AAAA);
    regWrite(32'h9C36_E1B4, 32'h0);
    sweep(32'h9C36_E1B4);
    regWrite(32'hFFFF_FFFF, 32'h0);
    sweep(32'hFFFF_FFFF);
    regRead(32'h8000_0000, rd);
    chk("R10", rd, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule